// File: doc/BRIEF.md
# Registered Separate-I/O Static Memory with Input-to-Output Pass-Through

This block is a single-clock synchronous static memory with independent data-in and data-out buses. The address, write data and three active-low controls are captured on each rising clock edge: chip enable, write enable and output enable. One edge later an output register loads either the word read from the array or the captured input word. The output register sits behind a 2:1 selector, so write data can appear on the output bus. A separate enable output tells the surrounding logic when to drive the output pins. The pins go high impedance only when a registered output-enable is inactive.

Chip enable does not deselect the memory. It only gates the array write. Reads still take place with chip enable inactive, and write data still passes through to the output with chip enable inactive. The address width is a parameter. The default is kept small for simulation, and 17 bits gives the full 131,072-word depth.

The captured command acts as a three-state register that is reloaded on every edge from {chip enable, write enable}:
- `OP_WRPASS` (both low): write the array and pass the data through.
- `OP_PASS` (chip enable high, write enable low): pass the data through without writing the array.
- `OP_READ` (write enable high, chip enable don't-care): read the array.

Any state can move to any state on the next edge, according to the new inputs. Reset enters `OP_READ`.

Top module: `sep_io_sync_sram`

## Requirements
- R1: Inputs applied before rising edge n are captured at edge n, and their result is visible on `dout_o`/`dout_en_o` right after edge n+1. Inputs may change freely after edge n without affecting that result.
- R2: With `ce_n_i`=0 and `we_n_i`=0 captured, `din_i` is stored at `addr_i` and also appears on `dout_o`.
- R3: With `ce_n_i`=1 and `we_n_i`=0 captured, `din_i` appears on `dout_o`, but the array is unchanged. A later read of that address returns the earlier contents.
- R4: With `we_n_i`=1 captured, `dout_o` shows the array word at the captured address, whatever the value of `ce_n_i`.
- R5: `dout_en_o` equals the inverse of the captured `oe_n_i`, delayed to line up with `dout_o`. `ce_n_i`=1 never clears it.
- R6: A read of an address written on the immediately preceding edge returns the new word.
- R7: While and after reset, `dout_en_o` is 0 until a low `oe_n_i` has been captured. Array contents after reset are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write / pass-through data |
| ce_n_i | input | 1 | Active-low chip enable (gates array write only) |
| we_n_i | input | 1 | Active-low write enable (selects pass-through) |
| oe_n_i | input | 1 | Active-low output enable |
| dout_o | output | DATA_W | Registered output word |
| dout_en_o | output | 1 | High when the output pins are driven |

## Verification
Writes with pass-through at several addresses and data patterns show that the selector picks the input word and that the array stores it. Pass-through cycles with chip enable inactive, followed by reads of the same address, tell a pass-only cycle apart from a real write. Reads with chip enable both low and high confirm that chip enable does not deselect the part. A write followed at once by a read of the same address probes the write-to-read ordering. Toggling output enable independently of chip enable separates the two controls on the enable output.

// File: rtl/sep_io_sram_pkg.sv
package sep_io_sram_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_PASS   = 2'd1,
        OP_WRPASS = 2'd2
    } sram_op_e;

    function automatic sram_op_e decode_op(input logic ce_n, input logic we_n);
        sram_op_e op;
        unique case ({ce_n, we_n})
            2'b00:   op = OP_WRPASS;
            2'b10:   op = OP_PASS;
            default: op = OP_READ;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/sep_io_sram_capture.sv
module sep_io_sram_capture
    import sep_io_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] din_q,
    output sram_op_e          op_q,
    output logic              oe_n_q
);

    sram_op_e op_next;

    always_comb begin
        op_next = decode_op(ce_n_i, we_n_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_q   <= OP_READ;
            oe_n_q <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            op_q   <= op_next;
            oe_n_q <= oe_n_i;
            addr_q <= addr_i;
            din_q  <= din_i;
        end
    end

    assert_no_write_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_n_i |=> (op_q != OP_WRPASS));

    assert_read_any_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_n_i |=> (op_q == OP_READ));

endmodule

// File: rtl/sep_io_sram_array.sv
module sep_io_sram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[addr_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = mem_q[addr_i];
    end

endmodule

// File: rtl/sep_io_sram_out_stage.sv
module sep_io_sram_out_stage
    import sep_io_sram_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  sram_op_e          op_i,
    input  logic [DATA_W-1:0] din_q_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              oe_n_q_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    logic [DATA_W-1:0] sel_data;

    always_comb begin
        unique case (op_i)
            OP_PASS, OP_WRPASS: sel_data = din_q_i;
            default:            sel_data = rd_data_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dout_o    <= '0;
            dout_en_o <= 1'b0;
        end else begin
            dout_o    <= sel_data;
            dout_en_o <= ~oe_n_q_i;
        end
    end

    assert_pass_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i != OP_READ) |=> (dout_o == $past(din_q_i)));

    assert_read_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_READ) |=> (dout_o == $past(rd_data_i)));

    assert_hiz_on_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_n_q_i |=> !dout_en_o);

    assert_drive_on_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_n_q_i |=> dout_en_o);

endmodule

// File: rtl/sep_io_sync_sram.sv
module sep_io_sync_sram
    import sep_io_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_en_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] rd_data;
    sram_op_e          op_q;
    logic              oe_n_q;
    logic              wr_en;

    sep_io_sram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .addr_i (addr_i),
        .din_i  (din_i),
        .ce_n_i (ce_n_i),
        .we_n_i (we_n_i),
        .oe_n_i (oe_n_i),
        .addr_q (addr_q),
        .din_q  (din_q),
        .op_q   (op_q),
        .oe_n_q (oe_n_q)
    );

    assign wr_en = (op_q == OP_WRPASS);

    sep_io_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en),
        .addr_i    (addr_q),
        .wr_data_i (din_q),
        .rd_data_o (rd_data)
    );

    sep_io_sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op_q),
        .din_q_i   (din_q),
        .rd_data_i (rd_data),
        .oe_n_q_i  (oe_n_q),
        .dout_o    (dout_o),
        .dout_en_o (dout_en_o)
    );

    assert_reset_quiet_R7: assert property (@(posedge clk_i)
        !rst_ni |=> !dout_en_o);

endmodule

// File: tb/sep_io_sync_sram_tb.sv
module sep_io_sync_sram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 9;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] din_i = '0;
    logic              ce_n_i = 1'b1;
    logic              we_n_i = 1'b1;
    logic              oe_n_i = 1'b1;
    logic [DATA_W-1:0] dout_o;
    logic              dout_en_o;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    bit done = 0;

    typedef struct {
        int                due;
        bit                chk_d;
        logic [DATA_W-1:0] d;
        bit                en;
        string             req;
    } exp_t;

    exp_t exp_q[$];
    logic [DATA_W-1:0] shadow [int];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    sep_io_sync_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .addr_i    (addr_i),
        .din_i     (din_i),
        .ce_n_i    (ce_n_i),
        .we_n_i    (we_n_i),
        .oe_n_i    (oe_n_i),
        .dout_o    (dout_o),
        .dout_en_o (dout_en_o)
    );

    task automatic drive(input int a, input int d, input bit ce_n, input bit we_n,
                         input bit oe_n, input string req);
        exp_t it;
        @(negedge clk_i);
        addr_i = a[ADDR_W-1:0];
        din_i  = d[DATA_W-1:0];
        ce_n_i = ce_n;
        we_n_i = we_n;
        oe_n_i = oe_n;
        it.due = ncyc + 2;
        it.en  = !oe_n;
        it.req = req;
        it.d   = '0;
        it.chk_d = 1'b0;
        if (!we_n) begin
            it.d = d[DATA_W-1:0];
            it.chk_d = 1'b1;
            if (!ce_n) shadow[a] = d[DATA_W-1:0];
        end else if (shadow.exists(a)) begin
            it.d = shadow[a];
            it.chk_d = 1'b1;
        end
        exp_q.push_back(it);
    endtask

    // monitor: compares results shortly after the edge that produces them
    initial begin
        forever begin
            @(posedge clk_i);
            ncyc++;
            #1;
            while (exp_q.size() > 0 && exp_q[0].due == ncyc) begin
                exp_t it;
                it = exp_q.pop_front();
                checks++;
                if (dout_en_o !== it.en) begin
                    errors++;
                    $display("FAIL %s enable: actual %0b expected %0b", it.req, dout_en_o, it.en);
                end
                if (it.chk_d) begin
                    checks++;
                    if (dout_o !== it.d) begin
                        errors++;
                        $display("FAIL %s data: actual %h expected %h", it.req, dout_o, it.d);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        checks++;
        if (dout_en_o !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset enable: actual %0b expected 0", dout_en_o);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);
        @(negedge clk_i);
        checks++;
        if (dout_en_o !== 1'b0) begin
            errors++;
            $display("FAIL R7 post-reset enable: actual %0b expected 0", dout_en_o);
        end

        // R2: write with pass-through, varied patterns
        drive(1, 'h155, 0, 0, 0, "R2");
        drive(2, 'h0AA, 0, 0, 0, "R2");
        drive(3, 'h1FF, 0, 0, 0, "R2");
        drive(63, 'h000, 0, 0, 0, "R2");
        // R1: inputs change every cycle, results follow two edges later
        drive(4, 'h123, 0, 0, 0, "R1");
        drive(5, 'h0F0, 0, 0, 0, "R1");
        // R4: reads with chip enable low and high
        drive(1, 'h1C3, 0, 1, 0, "R4");
        drive(2, 'h03C, 1, 1, 0, "R4");
        drive(63, 'h111, 1, 1, 0, "R4");
        // R3: pass-through with chip disabled, array untouched
        drive(3, 'h0A5, 1, 0, 0, "R3");
        drive(3, 'h000, 1, 1, 0, "R3");
        drive(4, 'h05A, 1, 0, 0, "R3");
        drive(4, 'h1FF, 0, 1, 0, "R3");
        // R6: write then immediate read of same address
        drive(7, 'h1E1, 0, 0, 0, "R6");
        drive(7, 'h000, 0, 1, 0, "R6");
        drive(7, 'h0E2, 0, 0, 0, "R6");
        drive(7, 'h000, 1, 1, 0, "R6");
        // R5: output enable independent of chip enable
        drive(1, 'h000, 0, 1, 1, "R5");
        drive(2, 'h000, 1, 1, 0, "R5");
        drive(5, 'h099, 1, 0, 1, "R5");
        drive(5, 'h000, 1, 1, 0, "R5");
        drive(6, 'h066, 0, 0, 1, "R5");
        drive(6, 'h000, 0, 1, 0, "R5");
        drive(0, 'h000, 1, 1, 1, "R5");
        drive(0, 'h000, 1, 1, 1, "R5");

        while (exp_q.size() > 0) @(negedge clk_i);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule